// File: doc/BRIEF.md
# Multiplexed LED Scan Engine with Dimming

This block drives a common-cathode LED panel one digit at a time. A scan timer steps through the grid lines in order. While a grid is selected, the segment lines show that digit's pattern, read from a 14-byte display memory. A 3-bit brightness code sets how long the segments stay lit within each grid slot. The code follows a nonlinear curve.

Two panel geometries are supported. In the first, 6 grids drive 12 segments. In the second, 7 grids drive 11 segments, and the twelfth segment pin becomes the seventh grid drive. A display enable blanks every output but leaves the scan running. A one-cycle pulse at the end of each full scan lets an external key scanner sample its matrix at a fixed point in the cycle.

The host loads configuration and memory through plain strobed inputs. A mode load changes the geometry. A control load sets the enable and the brightness code.

Top module: `led_scan_top`

## Requirements
- R1: At most one grid drive (grid_o bits, plus shared_o in 7-grid mode) is active at any time. Grids are visited in ascending order from index 0 to the last grid, then the order wraps. Each grid slot lasts 16 sub-slots of DIV clock cycles.
- R2: In sub-slot 0 of every grid slot, all grid and segment outputs are inactive, as a guard against ghosting.
- R3: With display on, grid drive is active in sub-slots 1 to 15. Segment outputs are enabled in sub-slots 1 to N, where N is 1, 2, 4, 10, 11, 12, 13 or 14 for brightness codes 0 to 7.
- R4: Mode code 2'b10 selects 6 grids. In this mode shared_o carries segment 12 of the current digit and is gated like the other segments.
- R5: Mode code 2'b11 selects 7 grids. In this mode shared_o is the seventh grid drive, and segment-12 data is not shown.
- R6: A mode load whose code has bit 1 clear leaves the mode unchanged. A load that changes the mode restarts the scan at grid 0, sub-slot 0.
- R7: For digit n, the low nibble of byte 2n drives seg_o[3:0], the high nibble of byte 2n drives seg_o[7:4], and bits [2:0] of byte 2n+1 drive seg_o[10:8]. Bit 3 of byte 2n+1 is segment 12. Bits [7:4] of byte 2n+1 are unused.
- R8: Memory writes to addresses 14 and 15 change no stored byte.
- R9: With display off, seg_o, grid_o and shared_o are all 0, while the scan and frame_end_o keep running.
- R10: frame_end_o is high for exactly one clock cycle: the last cycle of the last grid slot of every scan.
- R11: After reset the display is off and the block scans in 7-grid mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Display memory write strobe |
| wr_addr_i | input | 4 | Byte address (0 to 13 valid) |
| wr_data_i | input | 8 | Byte to write |
| mode_load_i | input | 1 | Geometry load strobe |
| mode_code_i | input | 2 | Geometry code (2'b10 or 2'b11) |
| ctl_load_i | input | 1 | Display control load strobe |
| disp_on_i | input | 1 | Display enable value to load |
| dim_code_i | input | 3 | Brightness code to load |
| seg_o | output | 11 | Segment drives 1 to 11, active high |
| grid_o | output | 6 | Grid drives 1 to 6, active high |
| shared_o | output | 1 | Segment 12 or grid 7, depending on mode |
| frame_end_o | output | 1 | One-cycle pulse at end of each scan |

## Verification
The bench walks all eight brightness codes and checks every sub-slot of every grid. An off-by-one in the on-window, or in the guard sub-slot, shows up as a digit lit one sub-slot too long or too short, or lit during the guard.

It switches geometry both ways and loads invalid mode codes. A design that mishandles the shared pin would leak segment 12 into the grid-7 drive, or drop it in 6-grid mode. A design that honours a bad mode code would change the scan length, and the frame pulse would arrive at the wrong cycle.

Writes to addresses 14 and 15 are followed by a full frame check. An address decoder that folds these addresses onto low bytes would corrupt a digit.

With the display off, the bench confirms that every output stays blank while frame_end_o still arrives on time.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int unsigned SUB_SLOTS = 16;
  localparam int unsigned SUB_W     = $clog2(SUB_SLOTS);
  localparam int unsigned MEM_BYTES = 14;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned MAX_GRIDS = 7;
  localparam int unsigned GRID_W    = $clog2(MAX_GRIDS);
  localparam int unsigned SEG_W     = 12;
  localparam int unsigned WIDTH_W   = SUB_W + 1;

  // Nonlinear on-time in sub-slots for each brightness code
  function automatic logic [WIDTH_W-1:0] dim_width(input logic [2:0] code);
    logic [WIDTH_W-1:0] n;
    case (code)
      3'd0:    n = WIDTH_W'(1);
      3'd1:    n = WIDTH_W'(2);
      3'd2:    n = WIDTH_W'(4);
      default: n = WIDTH_W'(7 + code);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer
  import led_scan_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [GRID_W-1:0] last_grid_i,
  output logic [SUB_W-1:0]  sub_o,
  output logic [GRID_W-1:0] grid_o,
  output logic              frame_end_o
);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [SUB_W-1:0]  sub_q;
  logic [GRID_W-1:0] grid_q;
  logic div_last, sub_last, grid_last;

  assign div_last  = (div_q == DIV_W'(DIV - 1));
  assign sub_last  = (sub_q == SUB_W'(SUB_SLOTS - 1));
  assign grid_last = (grid_q == last_grid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sub_q  <= '0;
      grid_q <= '0;
    end else if (restart_i) begin
      div_q  <= '0;
      sub_q  <= '0;
      grid_q <= '0;
    end else if (div_last) begin
      div_q <= '0;
      if (sub_last) begin
        sub_q  <= '0;
        grid_q <= grid_last ? '0 : grid_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sub_o       = sub_q;
  assign grid_o      = grid_q;
  assign frame_end_o = div_last && sub_last && grid_last;
endmodule

// File: rtl/led_scan_mem.sv
module led_scan_mem
  import led_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [GRID_W-1:0] rgrid_i,
  output logic [SEG_W-1:0]  seg_data_o
);
  logic [7:0]        mem_q [MEM_BYTES];
  logic [ADDR_W-1:0] lo_idx, hi_idx;
  logic [7:0]        lo_byte, hi_byte;

  for (genvar b = 0; b < MEM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[b] <= '0;
      else if (we_i && waddr_i == ADDR_W'(b))    mem_q[b] <= wdata_i;
    end
  end

  assign lo_idx = {rgrid_i, 1'b0};
  assign hi_idx = {rgrid_i, 1'b1};

  always_comb begin
    lo_byte = '0;
    hi_byte = '0;
    if (rgrid_i < GRID_W'(MAX_GRIDS)) begin
      lo_byte = mem_q[lo_idx];
      hi_byte = mem_q[hi_idx];
    end
  end

  // upper nibble of the odd byte is unused
  assign seg_data_o = {hi_byte[3:0], lo_byte};
endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive
  import led_scan_pkg::*;
(
  input  logic              disp_on_i,
  input  logic              mode7_i,
  input  logic [2:0]        dim_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [GRID_W-1:0] grid_i,
  input  logic [SEG_W-1:0]  seg_data_i,
  output logic [10:0]       seg_o,
  output logic [5:0]        grid_o,
  output logic              shared_o
);
  logic                 grid_act, seg_on;
  logic [WIDTH_W-1:0]   width;
  logic [MAX_GRIDS-1:0] grid_dec;

  assign width    = dim_width(dim_i);
  assign grid_act = disp_on_i && (sub_i != '0);
  assign seg_on   = grid_act && ({1'b0, sub_i} <= width);

  always_comb begin
    grid_dec = '0;
    for (int g = 0; g < MAX_GRIDS; g++)
      if (grid_act && grid_i == GRID_W'(g)) grid_dec[g] = 1'b1;
  end

  assign grid_o   = grid_dec[5:0];
  assign seg_o    = seg_on ? seg_data_i[10:0] : '0;
  assign shared_o = mode7_i ? grid_dec[6] : (seg_on & seg_data_i[11]);
endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        mode_load_i,
  input  logic [1:0]  mode_code_i,
  input  logic        ctl_load_i,
  input  logic        disp_on_i,
  input  logic [2:0]  dim_code_i,
  output logic [10:0] seg_o,
  output logic [5:0]  grid_o,
  output logic        shared_o,
  output logic        frame_end_o
);
  logic              mode7_q, disp_on_q;
  logic [2:0]        dim_q;
  logic              restart;
  logic [GRID_W-1:0] last_grid, grid_q;
  logic [SUB_W-1:0]  sub_q;
  logic [SEG_W-1:0]  seg_data;

  // only codes with bit 1 set are valid geometries
  assign restart   = mode_load_i && mode_code_i[1] && (mode_code_i[0] != mode7_q);
  assign last_grid = mode7_q ? GRID_W'(MAX_GRIDS - 1) : GRID_W'(MAX_GRIDS - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode7_q   <= 1'b1;
      disp_on_q <= 1'b0;
      dim_q     <= '0;
    end else begin
      if (mode_load_i && mode_code_i[1]) mode7_q <= mode_code_i[0];
      if (ctl_load_i) begin
        disp_on_q <= disp_on_i;
        dim_q     <= dim_code_i;
      end
    end
  end

  led_scan_timer #(.DIV(DIV)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .last_grid_i (last_grid),
    .sub_o       (sub_q),
    .grid_o      (grid_q),
    .frame_end_o (frame_end_o)
  );

  led_scan_mem u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en_i),
    .waddr_i    (wr_addr_i),
    .wdata_i    (wr_data_i),
    .rgrid_i    (grid_q),
    .seg_data_o (seg_data)
  );

  led_scan_drive u_drive (
    .disp_on_i  (disp_on_q),
    .mode7_i    (mode7_q),
    .dim_i      (dim_q),
    .sub_i      (sub_q),
    .grid_i     (grid_q),
    .seg_data_i (seg_data),
    .seg_o      (seg_o),
    .grid_o     (grid_o),
    .shared_o   (shared_o)
  );
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk
  import led_scan_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_load_i,
  input logic [1:0]        mode_code_i,
  input logic [10:0]       seg_o,
  input logic [5:0]        grid_o,
  input logic              shared_o,
  input logic              frame_end_o,
  input logic              mode7_q,
  input logic              disp_on_q,
  input logic [2:0]        dim_q,
  input logic [SUB_W-1:0]  sub_q,
  input logic [GRID_W-1:0] grid_q
);
  AST_GRID_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mode7_q & shared_o, grid_o})); // R1

  AST_GUARD_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q == '0) |-> (grid_o == '0 && seg_o == '0 && !shared_o)); // R2

  AST_SEG_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, sub_q} > dim_width(dim_q)) |-> (seg_o == '0 && !(shared_o && !mode7_q))); // R3

  AST_MODE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && !mode_code_i[1]) |=> $stable(mode7_q)); // R6

  AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && mode_code_i[1] && mode_code_i[0] != mode7_q)
      |=> (sub_q == '0 && grid_q == '0)); // R6

  AST_OFF_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_q |-> (seg_o == '0 && grid_o == '0 && !shared_o)); // R9

  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o); // R10
endmodule

bind led_scan_top led_scan_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_load_i (mode_load_i),
  .mode_code_i (mode_code_i),
  .seg_o       (seg_o),
  .grid_o      (grid_o),
  .shared_o    (shared_o),
  .frame_end_o (frame_end_o),
  .mode7_q     (mode7_q),
  .disp_on_q   (disp_on_q),
  .dim_q       (dim_q),
  .sub_q       (sub_q),
  .grid_q      (grid_q)
);

// File: tb/tb_led_scan_top.sv
`timescale 1ns/1ps
module tb_led_scan_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        mode_load = 1'b0;
  logic [1:0]  mode_code = '0;
  logic        ctl_load = 1'b0;
  logic        disp_on = 1'b0;
  logic [2:0]  dim_code = '0;
  logic [10:0] seg;
  logic [5:0]  grid;
  logic        shared;
  logic        frame_end;

  always #2.5 clk = ~clk;

  led_scan_top #(.DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mode_load_i(mode_load), .mode_code_i(mode_code),
    .ctl_load_i(ctl_load), .disp_on_i(disp_on), .dim_code_i(dim_code),
    .seg_o(seg), .grid_o(grid), .shared_o(shared), .frame_end_o(frame_end)
  );

  typedef struct {
    int    ng;
    int    g;
    bit    on;
    int    n;
    logic [11:0] pat;
    string tag;
  } item_t;

  item_t      q[$];
  logic [7:0] bmem [14];
  int  checks = 0, failures = 0;
  bit  busy = 0;
  bit  cur_mode7 = 1, cur_on = 0;
  int  cur_dim = 0;

  function automatic int width_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 7 + code;
    endcase
  endfunction

  // ---------------- monitor ----------------
  task automatic run_frame();
    item_t it;
    int ng;
    bit bad, fe_bad;
    string msg, fe_msg;
    logic [10:0] e_seg;
    logic [5:0]  e_grid;
    logic        e_sh, e_fe, g_act, s_on;
    busy = 1;
    ng = q[0].ng;
    fe_bad = 0;
    fe_msg = "";
    for (int g = 0; g < ng; g++) begin
      it = q.pop_front();
      bad = 0;
      msg = "";
      for (int s = 0; s < 16; s++) begin
        for (int d = 0; d < DIV; d++) begin
          @(negedge clk);
          g_act  = it.on && (s != 0);
          s_on   = g_act && (s <= it.n);
          e_seg  = s_on ? it.pat[10:0] : '0;
          e_grid = (g_act && g < 6) ? 6'(1 << g) : '0;
          e_sh   = (it.ng == 7) ? (g_act && g == 6) : (s_on && it.pat[11]);
          e_fe   = (g == ng - 1) && (s == 15) && (d == DIV - 1);
          if (!bad && (seg !== e_seg || grid !== e_grid || shared !== e_sh)) begin
            bad = 1;
            msg = $sformatf("FAIL %s (R1 R2 R3 R7) grid=%0d sub=%0d actual seg=%h grid=%b sh=%b expected seg=%h grid=%b sh=%b",
                            it.tag, g, s, seg, grid, shared, e_seg, e_grid, e_sh);
          end
          if (!fe_bad && frame_end !== e_fe) begin
            fe_bad = 1;
            fe_msg = $sformatf("FAIL R10 %s grid=%0d sub=%0d div=%0d actual frame_end=%b expected=%b",
                               it.tag, g, s, d, frame_end, e_fe);
          end
        end
      end
      checks++;
      if (bad) begin failures++; $display("%s", msg); end
    end
    checks++;
    if (fe_bad) begin failures++; $display("%s", fe_msg); end
    busy = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (frame_end && q.size() > 0) run_frame();
    end
  end

  // ---------------- driver ----------------
  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 14) bmem[a] = d;
  endtask

  task automatic set_mode(input logic [1:0] code);
    @(negedge clk);
    mode_load = 1; mode_code = code;
    @(negedge clk);
    mode_load = 0;
    if (code[1]) cur_mode7 = code[0];
  endtask

  task automatic set_ctl(input bit on, input int dim);
    @(negedge clk);
    ctl_load = 1; disp_on = on; dim_code = 3'(dim);
    @(negedge clk);
    ctl_load = 0;
    cur_on = on; cur_dim = dim;
  endtask

  task automatic expect_frames(input string tag, input int k);
    item_t it;
    int ng;
    ng = cur_mode7 ? 7 : 6;
    for (int f = 0; f < k; f++)
      for (int g = 0; g < ng; g++) begin
        it.ng = ng; it.g = g; it.on = cur_on; it.n = width_of(cur_dim);
        it.pat = {bmem[2*g+1][3:0], bmem[2*g]};
        it.tag = tag;
        q.push_back(it);
      end
    wait (q.size() == 0);
    wait (!busy);
  endtask

  bit done = 0;

  initial begin
    for (int a = 0; a < 14; a++) bmem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (seg !== '0 || grid !== '0 || shared !== 1'b0 || frame_end !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset outputs actual seg=%h grid=%b sh=%b fe=%b expected all 0",
               seg, grid, shared, frame_end);
    end
    // R11: display off, 7-grid period; R9 blank while scanning
    expect_frames("R11/R9 reset", 1);

    for (int a = 0; a < 14; a++) wr_byte(a, 8'((a * 37 + 91) ^ (a << 5)));
    // R3: every brightness code in 7-grid mode (R5, R7)
    for (int c = 0; c < 8; c++) begin
      set_ctl(1, c);
      expect_frames($sformatf("R3/R5 dim=%0d", c), 1);
    end

    // R4: six-grid geometry with segment 12 on the shared pin
    set_mode(2'b10);
    wr_byte(1, 8'h0F); wr_byte(5, 8'hF8); wr_byte(9, 8'h07);
    set_ctl(1, 5);
    expect_frames("R4 six-grid", 2);
    set_ctl(1, 3);
    expect_frames("R4/R3 six-grid", 1);

    // R6: invalid mode codes leave the geometry alone
    set_mode(2'b01);
    expect_frames("R6 code01", 1);
    set_mode(2'b00);
    expect_frames("R6 code00", 1);

    // R8: out-of-range writes change nothing
    wr_byte(14, 8'hFF);
    wr_byte(15, 8'hA5);
    expect_frames("R8 oob write", 1);

    // R9: display off in six-grid mode, scan continues
    set_ctl(0, 7);
    expect_frames("R9 off six-grid", 1);

    // R5: back to seven grids, segment-12 data hidden
    set_mode(2'b11);
    set_ctl(1, 7);
    expect_frames("R5/R6 seven-grid", 2);
    set_ctl(1, 0);
    expect_frames("R5/R2 seven-grid", 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule